// File: doc/BRIEF.md
# Dual-Channel Transmit Frame Buffer

This block holds outgoing frames for a MAC transmitter in two independent buffers. A processor loads both of them through one write-only register port. A channel index register chooses which buffer the shared 32-bit data register fills. Each buffer has its own byte-length register and its own go bit. After a frame is loaded, the processor writes its length and sets the go bit. The block then streams the stored bytes to the transmitter as a byte-wide valid/ready stream with an end-of-frame marker.

Only one frame is on the stream at any time. A channel that is started while the other channel is sending waits for the end of that frame. Each channel drives a busy pin while its go bit is set and a done flag once its frame has left. The downstream side can stall the stream at any byte. While `tx_valid` is high and `tx_ready` is low, the byte and its marker stay frozen. A byte counts as taken only on a clock edge where both `tx_valid` and `tx_ready` are high.

Register map (word addresses on `reg_addr`): 0 channel index, 1 data, 2 length of channel 0, 3 length of channel 1, 4 control of channel 0, 5 control of channel 1. All values below assume the default of two channels.

Top module: `txb_dual_tx_buffer`

## Requirements
- R1: After reset, `tx_valid` is 0 and both bits of `chan_busy` and `chan_done` are 0.
- R2: A started frame of length L leaves as exactly L bytes. The stored words are sent in the order they were written. Within each word, bits 7:0 go first and bits 31:24 go last. Bytes of the final word that lie beyond L are never sent.
- R3: `tx_last` is 1 on the byte with index L-1 of the frame and 0 on every other byte.
- R4: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R5: A write to address 0 with value c does two things. Later writes to address 1 go to channel c. The write position of channel c returns to word 0, so the next data write overwrites that channel's first word.
- R6: A write to address 4+c with bit 0 set, on an idle channel c whose length is not zero, sets `chan_busy[c]` on the next cycle and clears `chan_done[c]`. After the last byte is accepted, `chan_busy[c]` returns to 0 and `chan_done[c]` becomes 1. `tx_valid` is 0 in the cycle that follows.
- R7: A go write to a channel whose busy bit is set has no effect: no second frame follows.
- R8: Writes to a busy channel's length register and data writes aimed at a busy channel are ignored. Restarting that channel later sends the original frame again.
- R9: A channel started while the other channel is sending stays busy and begins only after the current frame's last byte. The two frames never interleave.
- R10: Data writes beyond the buffer capacity (DEPTH_WORDS words) are dropped and leave the stored words unchanged.
- R11: A go write to a channel whose length is 0 is ignored: the channel stays idle, no byte is sent and its done flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Transmitter accepts the byte |
| tx_last | output | 1 | Byte is the last of its frame |
| chan_busy | output | NUM_CH | Go bit of each channel (set while pending or sending) |
| chan_done | output | NUM_CH | Frame of the channel has been fully sent |

## Verification
The assertions rely on the processor writing a length no larger than the buffer capacity. They also rely on the processor loading at least ceil(L/4) words before it starts a channel, so every byte the stream reads has been written. The stimulus only uses lengths from 1 to the capacity of the small configuration. Every frame is loaded with exactly ceil(L/4) words before its go write. Words written after a buffer is full or while a channel is busy are never counted as frame content.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned BYTES_PER_WORD = WORD_W / 8;
  localparam int unsigned ADDR_CHSEL     = 0;
  localparam int unsigned ADDR_DATA      = 1;
  localparam int unsigned ADDR_LEN_BASE  = 2;
endpackage

// File: rtl/txb_reg_decode.sv
module txb_reg_decode #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CH_W-1:0]   wdata_ch,
  input  logic              wdata_go,
  output logic [NUM_CH-1:0] ptr_clr,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] len_we,
  output logic [NUM_CH-1:0] go_req
);
  import txb_pkg::*;

  localparam int unsigned CTL_BASE = ADDR_LEN_BASE + NUM_CH;

  logic [CH_W-1:0] sel_q;
  logic            sel_hit;
  logic            data_hit;

  assign sel_hit  = we && (addr == ADDR_W'(ADDR_CHSEL));
  assign data_hit = we && (addr == ADDR_W'(ADDR_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (sel_hit) sel_q <= wdata_ch;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign ptr_clr[c] = sel_hit && (wdata_ch == CH_W'(c));
    assign data_we[c] = data_hit && (sel_q == CH_W'(c));
    assign len_we[c]  = we && (addr == ADDR_W'(ADDR_LEN_BASE + c));
    assign go_req[c]  = we && wdata_go && (addr == ADDR_W'(CTL_BASE + c));
  end

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_we) && $onehot0(ptr_clr));
endmodule

// File: rtl/txb_chan_store.sv
module txb_chan_store #(
  parameter int unsigned DEPTH_WORDS = 16,
  parameter int unsigned LEN_W       = 7,
  parameter int unsigned IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_clr,
  input  logic             data_we,
  input  logic             len_we,
  input  logic             go_req,
  input  logic             fin,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word,
  output logic [LEN_W-1:0] len_q,
  output logic             busy,
  output logic             done
);
  localparam int unsigned PTR_W = $clog2(DEPTH_WORDS + 1);

  logic [31:0]      mem [DEPTH_WORDS];
  logic [PTR_W-1:0] wptr;
  logic             room;
  logic             store_en;

  assign room     = wptr < PTR_W'(DEPTH_WORDS);
  assign store_en = data_we && !busy && room;
  assign rd_word  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (store_en) mem[wptr[IDX_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      len_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      if (ptr_clr) wptr <= '0;
      else if (store_en) wptr <= wptr + PTR_W'(1);

      if (len_we && !busy) len_q <= wdata[LEN_W-1:0];

      if (fin) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (go_req && !busy && (len_q != '0)) begin
        busy <= 1'b1;
        done <= 1'b0;
      end
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fin |=> busy);
  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(fin));
  // R8
  len_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && len_we |=> $stable(len_q));
  // R10
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr == PTR_W'(DEPTH_WORDS)) && !ptr_clr |=> (wptr == PTR_W'(DEPTH_WORDS)));
  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_req && !busy && (len_q == '0) |=> !busy);
endmodule

// File: rtl/txb_serializer.sv
module txb_serializer #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1,
  parameter int unsigned LEN_W  = 7,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0]            pend,
  input  logic [NUM_CH-1:0][LEN_W-1:0] lens,
  input  logic [31:0]                  word_in,
  input  logic                         tx_ready,
  output logic [CH_W-1:0]              cur_ch,
  output logic [IDX_W-1:0]             word_idx,
  output logic [7:0]                   tx_data,
  output logic                         tx_valid,
  output logic                         tx_last,
  output logic [NUM_CH-1:0]            fin
);
  logic             active;
  logic [LEN_W-1:0] byte_idx;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] word_pos;
  logic [31:0]      shifted;
  logic [CH_W-1:0]  pick_ch;
  logic             pick_any;
  logic             fire;

  always_comb begin
    pick_ch  = '0;
    pick_any = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pend[c]) begin
        pick_ch  = CH_W'(c);
        pick_any = 1'b1;
      end
    end
  end

  assign cur_len  = lens[cur_ch];
  assign word_pos = byte_idx >> 2;
  assign word_idx = word_pos[IDX_W-1:0];
  assign shifted  = word_in >> {byte_idx[1:0], 3'b000};
  assign tx_data  = shifted[7:0];
  assign tx_valid = active;
  assign tx_last  = active && (byte_idx == cur_len - LEN_W'(1));
  assign fire     = active && tx_ready;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) fin[c] = fire && tx_last && (cur_ch == CH_W'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_ch   <= '0;
      byte_idx <= '0;
    end else if (!active) begin
      if (pick_any) begin
        active   <= 1'b1;
        cur_ch   <= pick_ch;
        byte_idx <= '0;
      end
    end else if (fire) begin
      if (tx_last) active <= 1'b0;
      else byte_idx <= byte_idx + LEN_W'(1);
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R9
  no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !(tx_ready && tx_last) |=> tx_valid && $stable(cur_ch));
  // R6
  end_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid);
endmodule

// File: rtl/txb_dual_tx_buffer.sv
module txb_dual_tx_buffer #(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned DEPTH_WORDS = 16,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic [NUM_CH-1:0] chan_busy,
  output logic [NUM_CH-1:0] chan_done
);
  import txb_pkg::*;

  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned BYTE_CAP = DEPTH_WORDS * BYTES_PER_WORD;
  localparam int unsigned LEN_W    = $clog2(BYTE_CAP + 1);
  localparam int unsigned IDX_W    = $clog2(DEPTH_WORDS);

  logic [NUM_CH-1:0]            ptr_clr, data_we, len_we, go_req, fin;
  logic [NUM_CH-1:0][LEN_W-1:0] lens;
  logic [NUM_CH-1:0][31:0]      words;
  logic [CH_W-1:0]              cur_ch;
  logic [IDX_W-1:0]             word_idx;

  txb_reg_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata_ch (reg_wdata[CH_W-1:0]),
    .wdata_go (reg_wdata[0]),
    .ptr_clr  (ptr_clr),
    .data_we  (data_we),
    .len_we   (len_we),
    .go_req   (go_req)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    txb_chan_store #(.DEPTH_WORDS(DEPTH_WORDS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr_clr (ptr_clr[c]),
      .data_we (data_we[c]),
      .len_we  (len_we[c]),
      .go_req  (go_req[c]),
      .fin     (fin[c]),
      .wdata   (reg_wdata),
      .rd_idx  (word_idx),
      .rd_word (words[c]),
      .len_q   (lens[c]),
      .busy    (chan_busy[c]),
      .done    (chan_done[c])
    );
  end

  txb_serializer #(.NUM_CH(NUM_CH), .CH_W(CH_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (chan_busy),
    .lens     (lens),
    .word_in  (words[cur_ch]),
    .tx_ready (tx_ready),
    .cur_ch   (cur_ch),
    .word_idx (word_idx),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .fin      (fin)
  );

  // R6
  valid_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> chan_busy[cur_ch]);
endmodule

// File: tb/test_txb_dual_tx_buffer.sv
`timescale 1ns/1ps
module test_txb_dual_tx_buffer;
  localparam int NCH = 2;
  localparam int DW  = 4;
  localparam int AW  = 4;
  localparam int CAP = DW * 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic           tx_ready = 1'b0;
  logic [7:0]     tx_data;
  logic           tx_valid, tx_last;
  logic [NCH-1:0] chan_busy, chan_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] model [NCH][DW];
  int mlen [NCH];

  always #4 clk = ~clk;

  txb_dual_tx_buffer #(.NUM_CH(NCH), .DEPTH_WORDS(DW), .ADDR_W(AW)) i_txb_dual_tx_buffer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .chan_busy(chan_busy), .chan_done(chan_done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) ^ (k << 4));
  endfunction

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic load(input int ch, input int len, input int seed);
    reg_wr(0, 32'(ch));
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] word;
      for (int b = 0; b < 4; b++) word[8*b +: 8] = pat(seed, 4 * w + b);
      reg_wr(1, word);
      model[ch][w] = word;
    end
    reg_wr(2 + ch, 32'(len));
    mlen[ch] = len;
  endtask

  task automatic start(input int ch);
    reg_wr(4 + ch, 32'h1);
    chk(chan_busy[ch] == 1'b1, "R6", "busy after go", int'(chan_busy[ch]), 1);
    chk(chan_done[ch] == 1'b0, "R6", "done cleared by go", int'(chan_done[ch]), 0);
  endtask

  task automatic recv(input int ch, input int mode, input string req);
    int k = 0;
    int guard = 0;
    bit held = 1'b0;
    logic [7:0] hd = '0;
    logic hl = 1'b0;
    while (k < mlen[ch] && guard < 400) begin
      @(negedge clk);
      guard++;
      if (held) begin
        chk(tx_valid && tx_data == hd && tx_last == hl, "R4", "stalled byte held", int'(tx_data), int'(hd));
        held = 1'b0;
      end
      tx_ready = (mode == 0) ? 1'b1 : ((guard % 3) != 0);
      if (tx_valid && tx_ready) begin
        logic [7:0] exp;
        exp = model[ch][k / 4][8 * (k % 4) +: 8];
        chk(tx_data == exp, "R2", "byte value", int'(tx_data), int'(exp));
        chk(tx_last == (k == mlen[ch] - 1), "R3", "last flag", int'(tx_last), int'(k == mlen[ch] - 1));
        k++;
      end else if (tx_valid) begin
        held = 1'b1; hd = tx_data; hl = tx_last;
      end
    end
    chk(k == mlen[ch], req, "frame byte count", k, mlen[ch]);
    @(negedge clk);
    tx_ready = 1'b0;
    chk(!tx_valid, "R6", "gap after last byte", int'(tx_valid), 0);
    chk(chan_busy[ch] == 1'b0, "R6", "busy cleared", int'(chan_busy[ch]), 0);
    chk(chan_done[ch] == 1'b1, "R6", "done raised", int'(chan_done[ch]), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tx_valid, "R1", "valid in reset", int'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid, "R1", "valid after reset", int'(tx_valid), 0);
    chk(chan_busy == '0, "R1", "busy after reset", int'(chan_busy), 0);
    chk(chan_done == '0, "R1", "done after reset", int'(chan_done), 0);

    // R2 R3 R4: sweep every length on both channels, free-running and stalled sink
    for (int ch = 0; ch < NCH; ch++)
      for (int len = 1; len <= CAP; len++)
        for (int mode = 0; mode < 2; mode++) begin
          load(ch, len, len * 3 + ch + mode * 50);
          start(ch);
          recv(ch, mode, "R2");
        end

    // R5: channel isolation and write-position reset
    load(0, 8, 200);
    load(1, 8, 201);
    start(0); recv(0, 0, "R5");
    start(1); recv(1, 1, "R5");
    reg_wr(0, 0);
    reg_wr(1, 32'h11223344);
    reg_wr(1, 32'h55667788);
    reg_wr(0, 0);
    reg_wr(1, 32'h99AABBCC);
    model[0][0] = 32'h99AABBCC;
    model[0][1] = 32'h55667788;
    start(0); recv(0, 0, "R5");

    // R10: one word beyond capacity is dropped
    reg_wr(0, 1);
    for (int w = 0; w <= DW; w++) begin
      reg_wr(1, 32'hC0DE0000 + 32'(w));
      if (w < DW) model[1][w] = 32'hC0DE0000 + 32'(w);
    end
    reg_wr(3, CAP);
    mlen[1] = CAP;
    start(1); recv(1, 0, "R10");

    // R11: go with zero length is ignored
    reg_wr(2, 0);
    reg_wr(4, 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(chan_busy[0] == 1'b0, "R11", "busy with zero length", int'(chan_busy[0]), 0);
      chk(!tx_valid, "R11", "no byte with zero length", int'(tx_valid), 0);
      chk(chan_done[0] == 1'b1, "R11", "done kept", int'(chan_done[0]), 1);
    end

    // R7 R8: writes to a busy channel
    load(0, CAP, 300);
    start(0);
    fork
      recv(0, 1, "R7");
      begin
        repeat (2) @(negedge clk);
        reg_wr(4, 1);
        reg_wr(2, 5);
        reg_wr(0, 0);
        reg_wr(1, 32'hA5A5A5A5);
      end
    join
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!tx_valid, "R7", "no repeat frame", int'(tx_valid), 0);
      chk(chan_busy[0] == 1'b0, "R7", "channel idle", int'(chan_busy[0]), 0);
    end
    start(0); recv(0, 0, "R8");

    // R9: second channel waits for the current frame
    load(0, 10, 400);
    load(1, 7, 401);
    start(0);
    fork
      recv(0, 0, "R9");
      begin
        repeat (2) @(negedge clk);
        reg_wr(5, 1);
      end
    join
    chk(chan_busy[1] == 1'b1, "R9", "waiting channel still busy", int'(chan_busy[1]), 1);
    recv(1, 1, "R9");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule